// File: doc/BRIEF.md
# SPI Accelerometer Polling Controller

This block is a hardware sequencer that talks to a three-axis accelerometer over a four-wire SPI link. It acts as the bus master and needs no processor. After reset it sends one register write that puts the sensor into measurement mode. It then sits idle until the host pulses `start_i`. A start makes it read the X, Y and Z samples in turn. Each axis is one burst that begins at the axis low-byte register, and each sample leaves the block as a signed 16-bit word with a one-cycle strobe.

A separate request input makes the block read the sensor's identification byte once. Every transaction starts with a header byte that carries three things: a read/write flag, a flag that marks a burst of more than one byte, and a six-bit register address. Chip select stays low for a fixed setup interval before the first clock edge. After chip select is released it stays high for a fixed recovery interval before any further transaction. Both intervals are derived from a clock-frequency parameter.

Top module: `accel_poll_ctrl`

## Requirements
- R1: While reset is asserted, `cs_n_o` and `sclk_o` are high and every valid strobe is low.
- R2: The first transaction after reset is a two-byte write. The header is 0x2D (bit 7 = 0, bit 6 = 0, address 0x2D in bits 5:0) and the data byte is 0x08.
- R3: The link uses SPI mode 3, MSB first. `sclk_o` is high whenever `cs_n_o` is high. MOSI changes on falling SCLK edges and MISO is sampled on rising edges. Every transaction is a whole number of bytes.
- R4: In the header, bit 7 is 1 for a read and 0 for a write, and bits 5:0 hold the register address. Bit 6 is 1 exactly when more than one data byte follows in the same chip-select window.
- R5: A `start_i` pulse accepted while idle produces three three-byte read transactions in the order X, Y, Z. Their headers are 0xF2, 0xF4 and 0xF6, for burst addresses 0x32, 0x34 and 0x36. Every byte the master sends after a read header is 0x00.
- R6: In each axis burst the first data byte received is the low byte and the second is the high byte. The output word is {high, low}, read as two's complement.
- R7: Each of `x_vld_o`, `y_vld_o`, `z_vld_o` and `id_vld_o` pulses for exactly one cycle. The pulse comes one cycle after `cs_n_o` rises at the end of its transaction, with its data output updated in the same cycle. No two strobes are ever high together.
- R8: `busy_o` is high in the cycle after an accepted `start_i` or `id_req_i`. It stays high through the Z strobe and the recovery gap that follows, and it is low when the block is idle.
- R9: An `id_req_i` pulse accepted while idle produces one two-byte read of address 0x00 with header 0x80. The received byte appears on `id_o` with an `id_vld_o` pulse.
- R10: `start_i` and `id_req_i` are ignored while `busy_o` is high. If both are high in the same idle cycle, the axis sequence runs and the identification read does not.
- R11: `cs_n_o` is low for at least ceil(CLK_HZ*SETUP_NS/1e9) cycles before the first falling SCLK edge. It is high for at least ceil(CLK_HZ*GAP_NS/1e9) cycles between transactions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request one X/Y/Z polling pass |
| id_req_i | input | 1 | Request one identification read |
| miso_i | input | 1 | Serial data from the sensor |
| sclk_o | output | 1 | Serial clock, idles high |
| mosi_o | output | 1 | Serial data to the sensor |
| cs_n_o | output | 1 | Active-low chip select |
| busy_o | output | 1 | Sequencer is not idle |
| x_o | output | 16 | Signed X sample |
| x_vld_o | output | 1 | X sample strobe |
| y_o | output | 16 | Signed Y sample |
| y_vld_o | output | 1 | Y sample strobe |
| z_o | output | 16 | Signed Z sample |
| z_vld_o | output | 1 | Z sample strobe |
| id_o | output | 8 | Identification byte |
| id_vld_o | output | 1 | Identification strobe |

## Verification
`busy_o` is due one cycle after a start or ID request is sampled. Each strobe is due exactly one cycle after the rising edge of `cs_n_o` that closes its burst. The setup and recovery intervals are lower bounds measured in whole cycles. A cycle-counting monitor samples every output on the falling clock edge. It measures the distance from each `cs_n_o` edge to the next SCLK fall, the next `cs_n_o` fall, or the strobe, and compares it with the bound computed in the bench from the timing parameters. A bus model of the sensor logs every header and byte, and the sequence checks read that log only after `busy_o` has dropped.

// File: rtl/accel_pkg.sv
`timescale 1ns/1ps
package accel_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 6;
  localparam int WORD_W = 2 * BYTE_W;

  localparam logic [ADDR_W-1:0] REG_ID  = 6'h00;
  localparam logic [ADDR_W-1:0] REG_PWR = 6'h2D;
  localparam logic [ADDR_W-1:0] REG_AX  = 6'h32;
  localparam logic [ADDR_W-1:0] REG_AY  = 6'h34;
  localparam logic [ADDR_W-1:0] REG_AZ  = 6'h36;
  localparam logic [BYTE_W-1:0] PWR_MEASURE = 8'h08;

  typedef enum logic [2:0] {
    OP_BOOT, OP_IDLE, OP_X, OP_Y, OP_Z, OP_ID
  } op_e;

  // header: [7] read, [6] burst, [5:0] address
  function automatic logic [BYTE_W-1:0] make_hdr(input logic rd, input logic burst,
                                                 input logic [ADDR_W-1:0] addr);
    return {rd, burst, addr};
  endfunction
endpackage

// File: rtl/accel_spi_shifter.sv
`timescale 1ns/1ps
module accel_spi_shifter #(
  parameter int HALF_CYC = 4,
  parameter int BW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_i,
  input  logic [BW-1:0] tx_i,
  input  logic          miso_i,
  output logic          done_o,
  output logic [BW-1:0] rx_o,
  output logic          sclk_o,
  output logic          mosi_o
);
  localparam int TW   = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam int CNTW = $clog2(BW + 1);

  logic          act_q, act_d;
  logic          sclk_q, sclk_d;
  logic          mosi_q, mosi_d;
  logic [BW-1:0] sh_q, sh_d;
  logic [CNTW-1:0] bc_q, bc_d;
  logic [TW-1:0] t_q, t_d;
  logic          tick;

  assign tick   = act_q && (t_q == TW'(HALF_CYC - 1));
  assign done_o = tick && sclk_q && (bc_q == CNTW'(BW));

  always_comb begin
    act_d  = act_q;
    sclk_d = sclk_q;
    mosi_d = mosi_q;
    sh_d   = sh_q;
    bc_d   = bc_q;
    t_d    = t_q;
    if (act_q) t_d = tick ? '0 : t_q + TW'(1);
    if (go_i) begin
      act_d  = 1'b1;
      sclk_d = 1'b0;
      mosi_d = tx_i[BW-1];
      sh_d   = tx_i;
      bc_d   = '0;
      t_d    = '0;
    end else if (tick) begin
      if (!sclk_q) begin
        sclk_d = 1'b1;
        sh_d   = {sh_q[BW-2:0], miso_i};
        bc_d   = bc_q + CNTW'(1);
      end else if (bc_q == CNTW'(BW)) begin
        act_d = 1'b0;
      end else begin
        sclk_d = 1'b0;
        mosi_d = sh_q[BW-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      sclk_q <= 1'b1;
      mosi_q <= 1'b0;
      sh_q   <= '0;
      bc_q   <= '0;
      t_q    <= '0;
    end else begin
      act_q  <= act_d;
      sclk_q <= sclk_d;
      mosi_q <= mosi_d;
      sh_q   <= sh_d;
      bc_q   <= bc_d;
      t_q    <= t_d;
    end
  end

  assign rx_o   = sh_q;
  assign sclk_o = sclk_q;
  assign mosi_o = mosi_q;

  // R3: the clock rests high whenever the shifter is idle
  assert_sclk_rest_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !act_q |-> sclk_q);
  // R3: never more than one byte of edges per load
  assert_bitcount_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bc_q <= CNTW'(BW));
endmodule

// File: rtl/accel_spi_xfer.sv
`timescale 1ns/1ps
module accel_spi_xfer #(
  parameter int SETUP_CYC = 50,
  parameter int GAP_CYC   = 5000,
  parameter int HALF_CYC  = 4,
  parameter int BW        = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic [BW-1:0] hdr_i,
  input  logic [BW-1:0] wdat_i,
  input  logic [1:0]    nbyte_i,
  output logic          rdy_o,
  output logic          fin_o,
  output logic [BW-1:0] lo_o,
  output logic [BW-1:0] hi_o,
  input  logic          miso_i,
  output logic          sclk_o,
  output logic          mosi_o,
  output logic          cs_n_o
);
  localparam int WAITMAX = (SETUP_CYC > GAP_CYC) ? SETUP_CYC : GAP_CYC;
  localparam int CW      = $clog2(WAITMAX + 1);

  typedef enum logic [1:0] {X_IDLE, X_SETUP, X_BYTE, X_GAP} xst_e;

  xst_e          st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [1:0]    idx_q, idx_d;
  logic [1:0]    n_q, n_d;
  logic [BW-1:0] hdr_q, hdr_d, wdat_q, wdat_d, lo_q, lo_d, hi_q, hi_d;
  logic          cs_q, cs_d, fin_q, fin_d;
  logic          go;
  logic [BW-1:0] txb, rxb;
  logic          sh_done;

  // byte to shift: header during setup, otherwise payload (zeros for reads)
  assign txb = (st_q == X_SETUP) ? hdr_q : (hdr_q[BW-1] ? '0 : wdat_q);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    idx_d  = idx_q;
    n_d    = n_q;
    hdr_d  = hdr_q;
    wdat_d = wdat_q;
    lo_d   = lo_q;
    hi_d   = hi_q;
    cs_d   = cs_q;
    fin_d  = 1'b0;
    go     = 1'b0;
    case (st_q)
      X_IDLE: if (req_i) begin
        st_d   = X_SETUP;
        cs_d   = 1'b0;
        cnt_d  = '0;
        idx_d  = '0;
        hdr_d  = hdr_i;
        wdat_d = wdat_i;
        n_d    = nbyte_i;
      end
      X_SETUP: if (cnt_q == CW'(SETUP_CYC - 1)) begin
        go   = 1'b1;
        st_d = X_BYTE;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
      X_BYTE: if (sh_done) begin
        if (idx_q == 2'd1) lo_d = rxb;
        if (idx_q == 2'd2) hi_d = rxb;
        if (idx_q == n_q - 2'd1) begin
          st_d  = X_GAP;
          cs_d  = 1'b1;
          fin_d = 1'b1;
          cnt_d = '0;
        end else begin
          go    = 1'b1;
          idx_d = idx_q + 2'd1;
        end
      end
      default: if (cnt_q == CW'(GAP_CYC - 1)) begin
        st_d = X_IDLE;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= X_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      n_q    <= '0;
      hdr_q  <= '0;
      wdat_q <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      cs_q   <= 1'b1;
      fin_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
      n_q    <= n_d;
      hdr_q  <= hdr_d;
      wdat_q <= wdat_d;
      lo_q   <= lo_d;
      hi_q   <= hi_d;
      cs_q   <= cs_d;
      fin_q  <= fin_d;
    end
  end

  accel_spi_shifter #(.HALF_CYC(HALF_CYC), .BW(BW)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .go_i   (go),
    .tx_i   (txb),
    .miso_i (miso_i),
    .done_o (sh_done),
    .rx_o   (rxb),
    .sclk_o (sclk_o),
    .mosi_o (mosi_o)
  );

  assign rdy_o  = (st_q == X_IDLE);
  assign fin_o  = fin_q;
  assign lo_o   = lo_q;
  assign hi_o   = hi_q;
  assign cs_n_o = cs_q;

  // R3: a released chip select always sees a resting clock
  assert_cs_sclk_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_q |-> sclk_o);
  // R11: chip select is never asserted while the recovery gap runs
  assert_gap_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == X_GAP) |-> cs_n_o);
endmodule

// File: rtl/accel_poll_ctrl.sv
`timescale 1ns/1ps
module accel_poll_ctrl
  import accel_pkg::*;
#(
  parameter int CLK_HZ    = 50_000_000,
  parameter int SCLK_HALF = 4,
  parameter int SETUP_NS  = 1000,
  parameter int GAP_NS    = 100_000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic                     id_req_i,
  input  logic                     miso_i,
  output logic                     sclk_o,
  output logic                     mosi_o,
  output logic                     cs_n_o,
  output logic                     busy_o,
  output logic signed [WORD_W-1:0] x_o,
  output logic                     x_vld_o,
  output logic signed [WORD_W-1:0] y_o,
  output logic                     y_vld_o,
  output logic signed [WORD_W-1:0] z_o,
  output logic                     z_vld_o,
  output logic [BYTE_W-1:0]        id_o,
  output logic                     id_vld_o
);
  localparam longint NS_PER_S = 64'd1_000_000_000;
  localparam longint SETUP_L  = (longint'(CLK_HZ) * SETUP_NS + NS_PER_S - 1) / NS_PER_S;
  localparam longint GAP_L    = (longint'(CLK_HZ) * GAP_NS + NS_PER_S - 1) / NS_PER_S;
  localparam int SETUP_CYC = (SETUP_L < 1) ? 1 : int'(SETUP_L);
  localparam int GAP_CYC   = (GAP_L < 1) ? 1 : int'(GAP_L);

  op_e  op_q, op_d;
  logic iss_q, iss_d;
  logic req, rdy, fin;
  logic [BYTE_W-1:0] hdr, wdat, lo, hi;
  logic [1:0] nb;

  logic signed [WORD_W-1:0] x_q, x_d, y_q, y_d, z_q, z_d;
  logic [BYTE_W-1:0] id_q, id_d;
  logic xv_q, xv_d, yv_q, yv_d, zv_q, zv_d, iv_q, iv_d;

  // transaction shape for the current operation
  always_comb begin
    hdr  = '0;
    wdat = '0;
    nb   = 2'd3;
    case (op_q)
      OP_BOOT: begin hdr = make_hdr(1'b0, 1'b0, REG_PWR); wdat = PWR_MEASURE; nb = 2'd2; end
      OP_X:    hdr = make_hdr(1'b1, 1'b1, REG_AX);
      OP_Y:    hdr = make_hdr(1'b1, 1'b1, REG_AY);
      OP_Z:    hdr = make_hdr(1'b1, 1'b1, REG_AZ);
      OP_ID:   begin hdr = make_hdr(1'b1, 1'b0, REG_ID); nb = 2'd2; end
      default: ;
    endcase
  end

  // sequencer: issue once per operation, advance when the link is free again
  always_comb begin
    op_d  = op_q;
    iss_d = iss_q;
    req   = 1'b0;
    if (op_q == OP_IDLE) begin
      if (start_i)       op_d = OP_X;
      else if (id_req_i) op_d = OP_ID;
    end else if (!iss_q) begin
      if (rdy) begin
        req   = 1'b1;
        iss_d = 1'b1;
      end
    end else if (rdy) begin
      iss_d = 1'b0;
      case (op_q)
        OP_X:    op_d = OP_Y;
        OP_Y:    op_d = OP_Z;
        default: op_d = OP_IDLE;
      endcase
    end
  end

  // result capture with single-cycle strobes
  always_comb begin
    x_d  = x_q;
    y_d  = y_q;
    z_d  = z_q;
    id_d = id_q;
    xv_d = 1'b0;
    yv_d = 1'b0;
    zv_d = 1'b0;
    iv_d = 1'b0;
    if (fin) begin
      case (op_q)
        OP_X:    begin x_d = {hi, lo}; xv_d = 1'b1; end
        OP_Y:    begin y_d = {hi, lo}; yv_d = 1'b1; end
        OP_Z:    begin z_d = {hi, lo}; zv_d = 1'b1; end
        OP_ID:   begin id_d = lo;      iv_d = 1'b1; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q  <= OP_BOOT;
      iss_q <= 1'b0;
      x_q   <= '0;
      y_q   <= '0;
      z_q   <= '0;
      id_q  <= '0;
      xv_q  <= 1'b0;
      yv_q  <= 1'b0;
      zv_q  <= 1'b0;
      iv_q  <= 1'b0;
    end else begin
      op_q  <= op_d;
      iss_q <= iss_d;
      x_q   <= x_d;
      y_q   <= y_d;
      z_q   <= z_d;
      id_q  <= id_d;
      xv_q  <= xv_d;
      yv_q  <= yv_d;
      zv_q  <= zv_d;
      iv_q  <= iv_d;
    end
  end

  accel_spi_xfer #(
    .SETUP_CYC (SETUP_CYC),
    .GAP_CYC   (GAP_CYC),
    .HALF_CYC  (SCLK_HALF),
    .BW        (BYTE_W)
  ) u_xfer (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (req),
    .hdr_i   (hdr),
    .wdat_i  (wdat),
    .nbyte_i (nb),
    .rdy_o   (rdy),
    .fin_o   (fin),
    .lo_o    (lo),
    .hi_o    (hi),
    .miso_i  (miso_i),
    .sclk_o  (sclk_o),
    .mosi_o  (mosi_o),
    .cs_n_o  (cs_n_o)
  );

  assign busy_o   = (op_q != OP_IDLE);
  assign x_o      = x_q;
  assign y_o      = y_q;
  assign z_o      = z_q;
  assign id_o     = id_q;
  assign x_vld_o  = xv_q;
  assign y_vld_o  = yv_q;
  assign z_vld_o  = zv_q;
  assign id_vld_o = iv_q;

  // R7: strobes never overlap
  assert_vld_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({xv_q, yv_q, zv_q, iv_q}));
  // R7: each strobe lasts one cycle
  assert_xvld_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    xv_q |=> !xv_q);
  // R7: a strobe follows the release of chip select
  assert_vld_after_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (xv_q || yv_q || zv_q || iv_q) |-> (cs_n_o && $past(cs_n_o)));
  // R8: the Z result arrives while still busy
  assert_busy_z_R8: assert property (@(posedge clk) disable iff (!rst_n)
    zv_q |-> busy_o);
  // R8: an accepted start raises busy on the next cycle
  assert_start_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);
endmodule

// File: tb/accel_poll_ctrl_tb.sv
`timescale 1ns/1ps
module accel_poll_ctrl_tb;
  localparam int CLK_PERIOD = 100;
  localparam int P_CLK_HZ   = 10_000_000;
  localparam int P_HALF     = 2;
  localparam int P_SETUP_NS = 1000;
  localparam int P_GAP_NS   = 100_000;
  localparam longint SETUP_C = (longint'(P_CLK_HZ) / 1000 * P_SETUP_NS + 999_999) / 1_000_000;
  localparam longint GAP_C   = (longint'(P_CLK_HZ) / 1000 * P_GAP_NS + 999_999) / 1_000_000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, id_req = 1'b0, miso = 1'b0;
  logic sclk, mosi, cs_n, busy;
  logic signed [15:0] x, y, z;
  logic x_vld, y_vld, z_vld, id_vld;
  logic [7:0] id;

  always #(CLK_PERIOD/2) clk = ~clk;

  accel_poll_ctrl #(
    .CLK_HZ(P_CLK_HZ), .SCLK_HALF(P_HALF), .SETUP_NS(P_SETUP_NS), .GAP_NS(P_GAP_NS)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .id_req_i(id_req), .miso_i(miso),
    .sclk_o(sclk), .mosi_o(mosi), .cs_n_o(cs_n), .busy_o(busy),
    .x_o(x), .x_vld_o(x_vld), .y_o(y), .y_vld_o(y_vld), .z_o(z), .z_vld_o(z_vld),
    .id_o(id), .id_vld_o(id_vld)
  );

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic signed [15:0] exp_word(input logic [7:0] lo, input logic [7:0] hi);
    return signed'({hi, lo});
  endfunction

  // ---------------- sensor bus model ----------------
  logic [7:0] mem [0:63];
  int bit_i = 0, byte_i = 0;
  logic [7:0] sr = '0, hdr_cur = '0;
  logic [7:0] rxb [0:3];
  logic [7:0] log_hdr [0:255];
  int         log_nb  [0:255];
  logic [7:0] log_b1  [0:255];
  int log_n = 0;

  always @(negedge cs_n) begin
    bit_i = 0;
    byte_i = 0;
  end

  always @(posedge sclk) if (!cs_n) begin
    sr = {sr[6:0], mosi};
    bit_i++;
    if (bit_i == 8) begin
      if (byte_i < 4) rxb[byte_i] = sr;
      if (byte_i == 0) hdr_cur = sr;
      byte_i++;
      bit_i = 0;
    end
  end

  always @(negedge sclk) if (!cs_n) begin
    if (byte_i == 0 || !hdr_cur[7]) miso <= 1'b0;
    else miso <= mem[(int'(hdr_cur[5:0]) + byte_i - 1) % 64][7 - bit_i];
  end

  always @(posedge cs_n) if (rst_n) begin
    chk(bit_i == 0, "R3", "whole bytes per window", bit_i, 0);
    chk(hdr_cur[6] == (byte_i > 2), "R4", "burst flag vs data bytes", hdr_cur, byte_i);
    if (hdr_cur[7])
      for (int k = 1; k < byte_i && k < 4; k++)
        chk(rxb[k] == 8'h00, "R5", "dummy byte", rxb[k], 0);
    log_hdr[log_n % 256] = hdr_cur;
    log_nb[log_n % 256]  = byte_i;
    log_b1[log_n % 256]  = rxb[1];
    log_n++;
  end

  // ---------------- cycle monitor ----------------
  longint cyc = 0, t_fall = 0, t_rise = 0;
  bit have_rise = 0, want_first = 0;
  logic prev_cs = 1'b1, prev_sclk = 1'b1, prev_xv = 1'b0;
  int since_rise = 0;
  int nx = 0, ny = 0, nz = 0, nid = 0;
  logic signed [15:0] cap_x, cap_y, cap_z;
  logic [7:0] cap_id;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (prev_cs && !cs_n) begin
        if (have_rise) chk(cyc - t_rise >= GAP_C, "R11", "recovery gap", cyc - t_rise, GAP_C);
        t_fall = cyc;
        want_first = 1;
      end
      if (!prev_cs && cs_n) begin
        t_rise = cyc;
        have_rise = 1;
        since_rise = 0;
      end else begin
        since_rise++;
      end
      if (want_first && prev_sclk && !sclk) begin
        chk(cyc - t_fall >= SETUP_C, "R11", "setup before first edge", cyc - t_fall, SETUP_C);
        want_first = 0;
      end
      if (cs_n && !sclk) chk(0, "R3", "sclk low with cs released", sclk, 1);
      if ($countones({x_vld, y_vld, z_vld, id_vld}) > 1)
        chk(0, "R7", "overlapping strobes", {x_vld, y_vld, z_vld, id_vld}, 0);
      if (x_vld && prev_xv) chk(0, "R7", "x strobe longer than one cycle", 2, 1);
      if (x_vld) begin nx++; cap_x = x; chk(since_rise == 1, "R7", "x strobe latency", since_rise, 1); end
      if (y_vld) begin ny++; cap_y = y; chk(since_rise == 1, "R7", "y strobe latency", since_rise, 1); end
      if (z_vld) begin
        nz++; cap_z = z;
        chk(since_rise == 1, "R7", "z strobe latency", since_rise, 1);
        chk(busy, "R8", "busy at z strobe", busy, 1);
      end
      if (id_vld) begin nid++; cap_id = id; chk(since_rise == 1, "R7", "id strobe latency", since_rise, 1); end
    end
    prev_cs = cs_n;
    prev_sclk = sclk;
    prev_xv = x_vld;
  end

  // ---------------- stimulus ----------------
  task automatic wait_idle(input int limit);
    int n = 0;
    while (busy && n < limit) begin @(negedge clk); n++; end
    chk(!busy, "R8", "busy returns low", busy, 0);
  endtask

  // mode 0 plain, 1 extra requests while busy, 2 start and id together
  task automatic axis_round(input logic [15:0] vx, input logic [15:0] vy,
                            input logic [15:0] vz, input int mode);
    int base;
    mem[8'h32] = vx[7:0]; mem[8'h33] = vx[15:8];
    mem[8'h34] = vy[7:0]; mem[8'h35] = vy[15:8];
    mem[8'h36] = vz[7:0]; mem[8'h37] = vz[15:8];
    base = log_n;
    nx = 0; ny = 0; nz = 0; nid = 0;
    start = 1'b1;
    if (mode == 2) id_req = 1'b1;
    @(negedge clk);
    start = 1'b0;
    id_req = 1'b0;
    chk(busy, "R8", "busy after start", busy, 1);
    if (mode == 1) begin
      repeat (60) @(negedge clk);
      start = 1'b1; id_req = 1'b1;
      @(negedge clk);
      start = 1'b0; id_req = 1'b0;
    end
    wait_idle(20000);
    repeat (3) @(negedge clk);
    chk(log_n - base == 3, "R10", "transactions per pass", log_n - base, 3);
    chk(nid == 0, "R10", "no id read in axis pass", nid, 0);
    if (log_n - base == 3) begin
      chk(log_hdr[base % 256] == 8'hF2 && log_nb[base % 256] == 3, "R5", "x header", log_hdr[base % 256], 8'hF2);
      chk(log_hdr[(base+1) % 256] == 8'hF4 && log_nb[(base+1) % 256] == 3, "R5", "y header", log_hdr[(base+1) % 256], 8'hF4);
      chk(log_hdr[(base+2) % 256] == 8'hF6 && log_nb[(base+2) % 256] == 3, "R5", "z header", log_hdr[(base+2) % 256], 8'hF6);
    end
    chk(nx == 1 && ny == 1 && nz == 1, "R7", "one strobe per axis", {nx[7:0], ny[7:0], nz[7:0]}, 24'h010101);
    chk(cap_x == exp_word(vx[7:0], vx[15:8]), "R6", "x word", cap_x, exp_word(vx[7:0], vx[15:8]));
    chk(cap_y == exp_word(vy[7:0], vy[15:8]), "R6", "y word", cap_y, exp_word(vy[7:0], vy[15:8]));
    chk(cap_z == exp_word(vz[7:0], vz[15:8]), "R6", "z word", cap_z, exp_word(vz[7:0], vz[15:8]));
  endtask

  task automatic id_read(input logic [7:0] v);
    int base;
    mem[0] = v;
    base = log_n;
    nid = 0;
    id_req = 1'b1;
    @(negedge clk);
    id_req = 1'b0;
    chk(busy, "R8", "busy after id request", busy, 1);
    wait_idle(20000);
    repeat (3) @(negedge clk);
    chk(log_n - base == 1, "R9", "one id transaction", log_n - base, 1);
    chk(log_hdr[base % 256] == 8'h80 && log_nb[base % 256] == 2, "R9", "id header", log_hdr[base % 256], 8'h80);
    chk(nid == 1 && cap_id == v, "R9", "id byte", cap_id, v);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd5150);
    for (int i = 0; i < 64; i++) mem[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    chk(cs_n && sclk && !x_vld && !y_vld && !z_vld && !id_vld, "R1", "reset outputs",
        {cs_n, sclk, x_vld, y_vld, z_vld, id_vld}, 6'b110000);
    rst_n = 1'b1;
    wait_idle(20000);
    repeat (3) @(negedge clk);
    chk(log_n == 1, "R2", "single boot transaction", log_n, 1);
    chk(log_hdr[0] == 8'h2D && log_nb[0] == 2, "R2", "boot header", log_hdr[0], 8'h2D);
    chk(log_b1[0] == 8'h08, "R2", "boot value", log_b1[0], 8'h08);

    axis_round(16'h8000, 16'h7FFF, 16'hFFFF, 0);
    axis_round(16'h0000, 16'h0001, 16'h1234, 0);
    id_read(8'hE5);
    axis_round(16'hA55A, 16'h00FF, 16'hFF00, 1);
    axis_round(16'h4321, 16'h8001, 16'h7F80, 2);
    for (int r = 0; r < 8; r++)
      axis_round(16'($urandom), 16'($urandom), 16'($urandom), r % 3);
    id_read(8'($urandom));

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 190000, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule